// File: doc/BRIEF.md
# Indirect Nonvolatile Memory Access Controller

This block lets a processor reach two storage arrays that do not appear in its register space. A byte-wide data store (256 locations) can be read and written. A word-wide program store (4096 words of 14 bits) can only be read. The processor works through a small bank of six byte registers: a control register, a write-unlock port, a low and a high data byte, and a low and a high address byte. A completed write raises an interrupt flag that stays set until software clears it.

A read is a single control-register write with the read-start bit set. One clock later the addressed value sits in the data registers. A write of the data store has a stricter order. Software first loads the address and data. It then writes the two key bytes to the unlock port. Its next register access must be the control write that sets the write-start bit, with the write-enable bit set and the data store selected. A fixed-length timer then runs the combined erase-and-store operation. There are two resets. A power-up reset clears everything. A warm reset (external or watchdog) aborts any write in progress and flags the abort, but keeps the address and data registers so that software can retry.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After power-up reset (`por_n` low), the control register reads 0x00, every other register reads 0x00 and `irq_done` is low. Register offsets: 0 control, 1 unlock port, 2 data low, 3 data high, 4 address low, 5 address high. Control bits: 0 read-start, 1 write-start/busy, 2 write-enable, 3 abort-error, 4 write-done, 7 select (0 data store, 1 program store).
- R2: A control write with bit 0 set and bit 7 clear loads the data store byte at the low address into the data-low register on the next clock. The read-start bit reads 1 for exactly that one cycle. The data-high register is left unchanged.
- R3: A control write with bits 0 and 7 set loads the program word at the 12-bit address {address-high[3:0], address-low} into {data-high[5:0], data-low} on the next clock. Data-high bits 7:6 read 0, and address-high bits 7:4 read 0. The program store holds word(a) = (a*37 + 0x155) mod 2^14.
- R4: Writing 0 to the write-start bit while a write is in progress does not clear it.
- R5: A write starts only if write-enable (bit 2) is set in the same control write that sets write-start. Otherwise the busy bit stays 0, no flag is set and the location keeps its old byte.
- R6: A write starts only if the unlock port received 0x55 and then 0xAA as the two register writes just before the starting control write. A wrong key order, or any other register write between the keys, discards the sequence.
- R7: A started write keeps the busy bit at 1 for exactly WR_CYCLES clocks. It then stores the byte at the low address, clears busy, and sets the write-done bit and `irq_done`.
- R8: The write-done flag is cleared only by a control write with bit 4 at 0. A control write with bit 4 at 1 leaves it set.
- R9: A warm reset (`rst_n` low) during a write clears busy and sets the abort-error bit. The target location keeps its old byte, and the address-low and data-low registers keep their values, so that a retry stores the byte.
- R10: The unlock port always reads 0x00.
- R11: A write attempted with the program store selected (bit 7 set) does not start and sets neither the done flag nor the error flag.
- R12: A power-up reset clears an abort-error flag set by a warm reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-up reset, clears all state |
| rst_n | input | 1 | Synchronous active-low warm reset, keeps address and data registers |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_done | output | 1 | Write-complete interrupt flag |

## Verification
The embedded properties assume that the processor never asserts the warm reset and the power-up reset in overlapping ways that matter. The power-up reset always wins, and the error-flag property is switched off while it is low. They also assume that register writes are single-cycle strobes with stable address and data. The bench drives every strobe for exactly one clock on the falling edge and samples reads a nanosecond after a falling edge. It changes no address or data register while a write is busy, and it reads only data store locations it has written before, because the array has no reset contents.

// File: rtl/nvm_pkg.sv
// Package: shared register offsets, control bit positions, unlock keys
// and the unlock-sequence state type for the access controller.
package nvm_pkg;
    localparam int REG_W = 8;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_UNLK = 3'd1;
    localparam logic [2:0] OFS_DLO  = 3'd2;
    localparam logic [2:0] OFS_DHI  = 3'd3;
    localparam logic [2:0] OFS_ALO  = 3'd4;
    localparam logic [2:0] OFS_AHI  = 3'd5;

    localparam int B_RD   = 0;
    localparam int B_WR   = 1;
    localparam int B_WEN  = 2;
    localparam int B_ERR  = 3;
    localparam int B_DONE = 4;
    localparam int B_SEL  = 7;

    localparam logic [REG_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [REG_W-1:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_HALF  = 2'd1,
        UNL_ARMED = 2'd2
    } unl_state_t;
endpackage

// File: rtl/nvm_unlock_seq.sv
// Unlock sequencer: tracks the two-key write-unlock order.
// Assumes: reg_wr is a one-cycle strobe; any register write other than
// the keys in order (including the consuming control write) disarms.
module nvm_unlock_seq
    import nvm_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             to_unlock,
    input  logic [REG_W-1:0] wdata,
    output logic             armed
);
    unl_state_t state;

    // Advance on key writes, fall back to idle on anything else.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            state <= UNL_IDLE;
        end else if (reg_wr) begin
            if (to_unlock && wdata == KEY_FIRST)
                state <= UNL_HALF;
            else if (to_unlock && wdata == KEY_SECOND && state == UNL_HALF)
                state <= UNL_ARMED;
            else
                state <= UNL_IDLE;
        end
    end

    assign armed = (state == UNL_ARMED);
endmodule

// File: rtl/nvm_wr_timer.sv
// Write timer: holds busy for a fixed number of clocks per write.
// Assumes: start is only raised while idle; either reset aborts.
module nvm_wr_timer #(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int CW = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count the write period and drop busy on its last cycle.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign finish = busy && (cnt == LAST);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        busy |-> (cnt <= LAST));
    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (busy && !finish) |=> busy);
    p_finish_drops_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (finish && !start) |=> !busy);
endmodule

// File: rtl/nvm_data_array.sv
// Data store: byte array with one synchronous write port and a
// combinational read port. Has no reset; contents are nonvolatile.
module nvm_data_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Erase-and-store of one byte, done as a single update.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_prog_rom.sv
// Program store: read-only word array whose contents are computed from
// the address as (a*MULT + OFFS) mod 2^WORD_W, so no table is kept.
module nvm_prog_rom #(
    parameter int          AW     = 12,
    parameter int          WORD_W = 14,
    parameter logic [13:0] MULT   = 14'd37,
    parameter logic [13:0] OFFS   = 14'h155
) (
    input  logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] a_ext;

    // Widen the address and form the stored word.
    always_comb begin
        a_ext = WORD_W'(addr);
        word  = a_ext * WORD_W'(MULT) + WORD_W'(OFFS);
    end
endmodule

// File: rtl/nvm_access_ctrl.sv
// Top: register bank giving a processor indirect access to a byte data
// store (read/write) and a word program store (read only).
// Assumes: reg_we is a one-cycle strobe; por_n outranks rst_n; address
// and data registers are not changed by software while a write is busy.
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int DATA_AW   = 8,
    parameter int PROG_AW   = 12,
    parameter int WORD_W    = 14,
    parameter int WR_CYCLES = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_done
);
    localparam int HI_W = WORD_W - REG_W;
    localparam int AH_W = PROG_AW - REG_W;

    logic [REG_W-1:0]  dlo, alo;
    logic [HI_W-1:0]   dhi;
    logic [AH_W-1:0]   ahi;
    logic              rd_go, wr_ena, err, done_flag, sel_prog;
    logic              armed, wr_busy, wr_finish, wr_start, rd_start;
    logic              ctrl_wr, mem_we;
    logic [REG_W-1:0]  mem_rdata;
    logic [WORD_W-1:0] rom_word;

    assign ctrl_wr  = reg_we && (reg_addr == OFS_CTRL);
    assign wr_start = ctrl_wr && reg_wdata[B_WR] && reg_wdata[B_WEN]
                      && !reg_wdata[B_SEL] && armed && !wr_busy;
    assign rd_start = ctrl_wr && reg_wdata[B_RD] && !wr_busy && !wr_start && !rd_go;
    assign mem_we   = wr_finish && rst_n && por_n;

    nvm_unlock_seq u_unlock (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .reg_wr    (reg_we),
        .to_unlock (reg_addr == OFS_UNLK),
        .wdata     (reg_wdata),
        .armed     (armed)
    );

    nvm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .start  (wr_start),
        .busy   (wr_busy),
        .finish (wr_finish)
    );

    nvm_data_array #(.AW(DATA_AW), .DW(REG_W)) u_data (
        .clk   (clk),
        .we    (mem_we),
        .waddr (alo[DATA_AW-1:0]),
        .wdata (dlo),
        .raddr (alo[DATA_AW-1:0]),
        .rdata (mem_rdata)
    );

    nvm_prog_rom #(.AW(PROG_AW), .WORD_W(WORD_W)) u_rom (
        .addr ({ahi, alo}),
        .word (rom_word)
    );

    // Control bits: software-settable starts, write-0-to-clear flags.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rd_go     <= 1'b0;
            wr_ena    <= 1'b0;
            sel_prog  <= 1'b0;
            err       <= 1'b0;
            done_flag <= 1'b0;
        end else if (!rst_n) begin
            rd_go    <= 1'b0;
            wr_ena   <= 1'b0;
            sel_prog <= 1'b0;
            err      <= err | wr_busy;
        end else begin
            if (ctrl_wr) begin
                wr_ena   <= reg_wdata[B_WEN];
                sel_prog <= reg_wdata[B_SEL];
                err      <= err & reg_wdata[B_ERR];
            end
            if (wr_finish)    done_flag <= 1'b1;
            else if (ctrl_wr) done_flag <= done_flag & reg_wdata[B_DONE];
            if (rd_start)     rd_go <= 1'b1;
            else              rd_go <= 1'b0;
        end
    end

    // Address and data registers: software writes, read results; kept on warm reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            dlo <= '0;
            dhi <= '0;
            alo <= '0;
            ahi <= '0;
        end else if (rst_n) begin
            if (reg_we && reg_addr == OFS_ALO) alo <= reg_wdata;
            if (reg_we && reg_addr == OFS_AHI) ahi <= reg_wdata[AH_W-1:0];
            if (rd_go && sel_prog) begin
                {dhi, dlo} <= rom_word;
            end else if (rd_go) begin
                dlo <= mem_rdata;
            end else begin
                if (reg_we && reg_addr == OFS_DLO) dlo <= reg_wdata;
                if (reg_we && reg_addr == OFS_DHI) dhi <= reg_wdata[HI_W-1:0];
            end
        end
    end

    // Register read multiplexer; the unlock port has no storage.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[B_RD]   = rd_go;
                reg_rdata[B_WR]   = wr_busy;
                reg_rdata[B_WEN]  = wr_ena;
                reg_rdata[B_ERR]  = err;
                reg_rdata[B_DONE] = done_flag;
                reg_rdata[B_SEL]  = sel_prog;
            end
            OFS_DLO: reg_rdata = dlo;
            OFS_DHI: reg_rdata = REG_W'(dhi);
            OFS_ALO: reg_rdata = alo;
            OFS_AHI: reg_rdata = REG_W'(ahi);
            default: reg_rdata = '0;
        endcase
    end

    assign irq_done = done_flag;

    p_rd_one_cycle_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rd_go |=> !rd_go);
    p_start_needs_key_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(wr_busy) |-> $past(armed));
    p_start_needs_enable_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(wr_busy) |-> wr_ena);
    p_prog_never_written_r11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(wr_busy) |-> !sel_prog);
    p_done_after_finish_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        wr_finish |=> done_flag);
    p_abort_flags_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && wr_busy) |=> (err && !wr_busy));
endmodule

// File: tb/tb_nvm_access_ctrl.sv
module tb_nvm_access_ctrl;
    localparam int W = 8;
    localparam logic [2:0] A_CTRL = 3'd0, A_UNLK = 3'd1, A_DLO = 3'd2,
                           A_DHI = 3'd3, A_ALO = 3'd4, A_AHI = 3'd5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nvm_access_ctrl #(.WR_CYCLES(W)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_done(irq_done)
    );

    // {address, byte} pairs written and read back by the loop
    localparam logic [15:0] VEC [6] = '{16'h00_3C, 16'hFF_C3, 16'h10_11,
                                        16'h7E_A5, 16'h81_00, 16'h20_FF};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        wr(A_ALO, a); wr(A_DLO, d); wr(A_CTRL, 8'h04);
        wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA); wr(A_CTRL, 8'h06);
    endtask

    task automatic full_write(input logic [7:0] a, input logic [7:0] d);
        start_write(a, d);
        repeat (W) @(negedge clk);
    endtask

    task automatic read_data(input logic [7:0] a, output logic [7:0] v);
        wr(A_ALO, a); wr(A_CTRL, 8'h01);
        @(negedge clk);
        rd(A_DLO, v);
    endtask

    function automatic logic [13:0] prog_word(input logic [11:0] a);
        int t;
        t = (int'(a) * 37 + 341) % 16384;
        return t[13:0];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        rd(A_DLO, v);  chk("R1 dlo", v, 8'h00);
        rd(A_AHI, v);  chk("R1 ahi", v, 8'h00);
        chk("R1 irq", irq_done, 1'b0);

        // R7/R2 vector loop: write each byte, read it back
        foreach (VEC[i]) begin
            full_write(VEC[i][15:8], VEC[i][7:0]);
            read_data(VEC[i][15:8], v);
            chk("R7 R2 readback", v, VEC[i][7:0]);
        end

        // R2 read-start visible for one cycle, dhi untouched
        wr(A_DHI, 8'h2B);
        wr(A_ALO, 8'h7E); wr(A_CTRL, 8'h01);
        rd(A_CTRL, v); chk("R2 rd bit set", v, 8'h01);
        @(negedge clk);
        rd(A_CTRL, v); chk("R2 rd bit cleared", v, 8'h00);
        rd(A_DLO, v);  chk("R2 dlo", v, 8'hA5);
        rd(A_DHI, v);  chk("R2 dhi unchanged", v, 8'h2B);

        // R3 program reads
        for (int k = 0; k < 4; k++) begin
            logic [11:0] pa;
            logic [13:0] w;
            pa = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h5A3 : 12'h801;
            w = prog_word(pa);
            wr(A_ALO, pa[7:0]); wr(A_AHI, {4'hF, pa[11:8]}); wr(A_CTRL, 8'h81);
            @(negedge clk);
            rd(A_DLO, v); rd(A_DHI, v2);
            chk("R3 prog word", {v2, v}, {2'b00, w});
        end
        rd(A_AHI, v); chk("R3 ahi upper zero", v, 8'h08);

        // R7 exact busy length and done flag
        start_write(8'h40, 8'h9D);
        repeat (W - 1) @(negedge clk);
        rd(A_CTRL, v); chk("R7 busy last cycle", v, 8'h06);
        @(negedge clk);
        rd(A_CTRL, v); chk("R7 done after period", v, 8'h14);
        chk("R7 irq", irq_done, 1'b1);

        // R8 done cleared only by writing 0
        wr(A_CTRL, 8'h14);
        rd(A_CTRL, v); chk("R8 write 1 keeps done", v, 8'h14);
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, v); chk("R8 write 0 clears done", v, 8'h04);
        chk("R8 irq low", irq_done, 1'b0);

        // R4 write of 0 to start bit during busy
        start_write(8'h41, 8'h5E);
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, v); chk("R4 busy kept", v[1], 1'b1);
        repeat (W) @(negedge clk);
        read_data(8'h41, v); chk("R4 write completed", v, 8'h5E);

        // R5 no enable in the starting write
        wr(A_ALO, 8'h40); wr(A_DLO, 8'h01); wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA);
        wr(A_CTRL, 8'h02);
        rd(A_CTRL, v); chk("R5 no start", v, 8'h00);
        repeat (W + 1) @(negedge clk);
        read_data(8'h40, v); chk("R5 location kept", v, 8'h9D);

        // R6 wrong key order
        wr(A_ALO, 8'h40); wr(A_DLO, 8'h02); wr(A_CTRL, 8'h04);
        wr(A_UNLK, 8'hAA); wr(A_UNLK, 8'h55); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); chk("R6 wrong order", v, 8'h04);
        // R6 intervening register write
        wr(A_UNLK, 8'h55); wr(A_ALO, 8'h40); wr(A_UNLK, 8'hAA); wr(A_CTRL, 8'h06);
        rd(A_CTRL, v); chk("R6 interrupted keys", v, 8'h04);
        repeat (W + 1) @(negedge clk);
        read_data(8'h40, v); chk("R6 location kept", v, 8'h9D);

        // R10 unlock port reads zero
        wr(A_UNLK, 8'h55);
        rd(A_UNLK, v); chk("R10 unlock reads 0", v, 8'h00);

        // R11 write with program store selected
        wr(A_ALO, 8'h40); wr(A_DLO, 8'h03); wr(A_CTRL, 8'h84);
        wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA); wr(A_CTRL, 8'h86);
        rd(A_CTRL, v); chk("R11 no start no flags", v, 8'h84);
        repeat (W + 1) @(negedge clk);
        rd(A_CTRL, v); chk("R11 still no flags", v, 8'h84);
        read_data(8'h40, v); chk("R11 location kept", v, 8'h9D);

        // R9 warm reset during a write
        start_write(8'h10, 8'h77);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_CTRL, v); chk("R9 error set busy cleared", v, 8'h08);
        rd(A_ALO, v);  chk("R9 address kept", v, 8'h10);
        rd(A_DLO, v);  chk("R9 data kept", v, 8'h77);
        repeat (W) @(negedge clk);
        read_data(8'h10, v); chk("R9 location old", v, 8'h11);
        full_write(8'h10, 8'h77);
        read_data(8'h10, v); chk("R9 retry stores", v, 8'h77);

        // R12 power-up reset clears error
        start_write(8'h11, 8'h22);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_CTRL, v); chk("R12 error before por", v[3], 1'b1);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd(A_CTRL, v); chk("R12 error cleared", v, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule